// File: doc/BRIEF.md
# Parallel Dual-Tone I/Q Test Generator

This block produces a synthetic complex baseband stream for a dual converter whose sample clock is four times the fabric clock. It contains four phase-accumulating tone sources. Two of them feed the in-phase channel and two feed the quadrature channel. Each tone is weighted by its own gain, and the two weighted tones of a channel are added with saturation. On every fabric clock the block emits four time-consecutive 16-bit samples per channel as one packed word, ready for a 4:1 serializer. For example, a 125 MHz fabric clock yields 500 MS/s at the converter.

Tuning words and gains are plain register inputs held steady by the surrounding logic. A synchronous clear rewinds every tone to phase zero and restarts the output pipeline. The valid flag rises a fixed three clocks after the clear is released.

Top module: `dual_tone_iq_gen`

## Requirements
- R1: Each tone keeps a 32-bit phase accumulator that advances by 4 times its tuning word per clock. Lane k (k = 0..3) of a clock uses accumulator + k x tuning word. Sample number j after a clear therefore has phase j x tuning word, modulo 2^32.
- R2: The amplitude of a tone is looked up from the top 10 bits of its lane phase. Bits 9:8 select the quadrant and bits 7:0 give an offset a. Quadrant 0 gives +T[a], quadrant 1 gives +T[255-a], quadrant 2 gives -T[a] and quadrant 3 gives -T[255-a]. T[i] = floor(32767 x n x (786432 - n^2) / 268435456), with n = 2i+1.
- R3: A gain is an unsigned Q1.15 value on a 16-bit input, where 0x8000 means unity; any value above 0x8000 acts as 0x8000. The weighted tone is floor(amplitude x gain / 32768).
- R4: The two weighted tones of a channel are added, and the sum is saturated to [-32768, 32767].
- R5: In each 64-bit output word, lane k sits at bits 16k+15:16k. Lane 3 is the newest sample and occupies the most significant position.
- R6: When clear is high at a clock edge, out_valid is low after that edge. The first valid word after the clear is released holds samples 0..3 of a stream that starts at phase zero.
- R7: out_valid rises on the third clock edge after the first cycle in which clear is low. It then stays high while clear stays low.
- R8: During and right after a synchronous reset, out_valid is low and both output words are zero.
- R9: When both gains of a channel are zero, that channel's valid output words are zero.
- R10: The I and Q channels are computed independently from their own tuning words and gains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous phase clear and pipeline restart |
| ftw_i_a | input | 32 | Tuning word, first I tone |
| ftw_i_b | input | 32 | Tuning word, second I tone |
| ftw_q_a | input | 32 | Tuning word, first Q tone |
| ftw_q_b | input | 32 | Tuning word, second Q tone |
| gain_i_a | input | 16 | Q1.15 gain, first I tone |
| gain_i_b | input | 16 | Q1.15 gain, second I tone |
| gain_q_a | input | 16 | Q1.15 gain, first Q tone |
| gain_q_b | input | 16 | Q1.15 gain, second Q tone |
| i_word | output | 64 | Four packed I samples, newest at the top |
| q_word | output | 64 | Four packed Q samples, newest at the top |
| out_valid | output | 1 | Output words are valid |

## Verification
A single tone at unity gain, stepping exactly one table position per sample, walks all 1024 phase positions. This exposes any wrong table entry, quadrant fold or lane order. Mixed tones at fractional gains test the floor rounding of negative products and the addition. Two in-phase full-gain tones, together with an over-range gain, drive the sum into both rails, which separates saturation from wrap-around and shows the gain clamp. Zero gains, large odd tuning words that wrap the accumulator, and differing I and Q settings separate the channels and check the modulo-2^32 phase arithmetic.

// File: rtl/iqgen_pkg.sv
package iqgen_pkg;

  // Quadrant of the folded sine table
  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_NRISE = 2'd2,
    QD_NFALL = 2'd3
  } quad_e;

  // Quarter-wave magnitude at index idx: cubic approximation of sin
  // sampled at the centre of each of the 2^addr_w bins.
  function automatic longint quarter_amp(input int idx, input int addr_w, input int amp_w);
    longint d;
    longint n;
    longint peak;
    d    = longint'(1) << (addr_w + 1);
    n    = 2 * longint'(idx) + 1;
    peak = (longint'(1) << (amp_w - 1)) - 1;
    return (peak * n * (3 * d * d - n * n)) / (2 * d * d * d);
  endfunction

endpackage

// File: rtl/sine_quarter_rom.sv
module sine_quarter_rom #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 15,
  parameter int PORTS  = 4
) (
  input  logic [PORTS*ADDR_W-1:0] rd_addr,
  output logic [PORTS*MAG_W-1:0]  rd_mag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign tbl[e] = MAG_W'(iqgen_pkg::quarter_amp(e, ADDR_W, MAG_W + 1));
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign rd_mag[p*MAG_W +: MAG_W] = tbl[rd_addr[p*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen #(
  parameter int PHASE_W = 32,
  parameter int LANES   = 4,
  parameter int OUT_W   = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic [PHASE_W-1:0]     ftw,
  output logic [LANES*OUT_W-1:0] lane_top
);
  localparam int DROP = PHASE_W - OUT_W;

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] clk_step;

  assign clk_step = PHASE_W'(LANES) * ftw;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else              acc_q <= acc_q + clk_step;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] lane_ph;
    assign lane_ph = acc_q + PHASE_W'(k) * ftw;
    assign lane_top[k*OUT_W +: OUT_W] = OUT_W'(lane_ph >> DROP);
  end
endmodule

// File: rtl/tone_lookup.sv
module tone_lookup #(
  parameter int LUT_BITS = 10,
  parameter int AMP_W    = 16,
  parameter int LANES    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*LUT_BITS-1:0] lane_top,
  output logic [LANES*AMP_W-1:0]    amp_q
);
  import iqgen_pkg::*;

  localparam int ADDR_W = LUT_BITS - 2;
  localparam int MAG_W  = AMP_W - 1;

  logic [LANES*ADDR_W-1:0] rom_addr;
  logic [LANES*MAG_W-1:0]  rom_mag;
  logic [LANES-1:0]        lane_neg;
  logic [LANES*AMP_W-1:0]  amp_d;

  function automatic logic [ADDR_W-1:0] fold_addr(input quad_e q, input logic [ADDR_W-1:0] off);
    return (q == QD_FALL || q == QD_NFALL) ? ~off : off;
  endfunction

  function automatic logic [AMP_W-1:0] apply_sign(input logic neg, input logic [MAG_W-1:0] mag);
    logic [AMP_W-1:0] m;
    m = {1'b0, mag};
    return neg ? (~m + 1'b1) : m;
  endfunction

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      quad_e q;
      q = quad_e'(lane_top[k*LUT_BITS + ADDR_W +: 2]);
      rom_addr[k*ADDR_W +: ADDR_W] = fold_addr(q, lane_top[k*LUT_BITS +: ADDR_W]);
      lane_neg[k] = (q == QD_NRISE) || (q == QD_NFALL);
    end
  end

  sine_quarter_rom #(
    .ADDR_W(ADDR_W),
    .MAG_W (MAG_W),
    .PORTS (LANES)
  ) rom_i (
    .rd_addr(rom_addr),
    .rd_mag (rom_mag)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      amp_d[k*AMP_W +: AMP_W] = apply_sign(lane_neg[k], rom_mag[k*MAG_W +: MAG_W]);
    end
  end

  // Pipeline stage 1: signed amplitudes
  always_ff @(posedge clk) begin
    if (rst) amp_q <= '0;
    else     amp_q <= amp_d;
  end
endmodule

// File: rtl/channel_mixer.sv
module channel_mixer #(
  parameter int AMP_W   = 16,
  parameter int SCALE_W = 16,
  parameter int LANES   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES*AMP_W-1:0]   amp_a,
  input  logic [LANES*AMP_W-1:0]   amp_b,
  input  logic [SCALE_W-1:0]       gain_a,
  input  logic [SCALE_W-1:0]       gain_b,
  output logic [LANES*AMP_W-1:0]   word_q
);
  localparam int UNITY  = 1 << (SCALE_W - 1);
  localparam int PROD_W = AMP_W + SCALE_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((2 ** (AMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = ~S_MAX;

  function automatic logic [SCALE_W:0] clamp_gain(input logic [SCALE_W-1:0] g);
    return (g > SCALE_W'(UNITY)) ? (SCALE_W + 1)'(UNITY) : {1'b0, g};
  endfunction

  function automatic logic signed [PROD_W-1:0] weigh(input logic signed [AMP_W-1:0] amp,
                                                     input logic [SCALE_W:0] g);
    logic signed [PROD_W-1:0] p;
    p = amp * $signed({1'b0, g});
    return p >>> (SCALE_W - 1);
  endfunction

  function automatic logic [AMP_W-1:0] saturate(input logic signed [SUM_W-1:0] s);
    if (s > S_MAX)      return AMP_W'(S_MAX);
    else if (s < S_MIN) return AMP_W'(S_MIN);
    else                return AMP_W'(s);
  endfunction

  logic [SCALE_W:0] g_a_eff;
  logic [SCALE_W:0] g_b_eff;
  logic signed [PROD_W-1:0] wa_d [LANES];
  logic signed [PROD_W-1:0] wb_d [LANES];
  logic signed [PROD_W-1:0] wa_q [LANES];
  logic signed [PROD_W-1:0] wb_q [LANES];
  logic [LANES*AMP_W-1:0]   word_d;

  assign g_a_eff = clamp_gain(gain_a);
  assign g_b_eff = clamp_gain(gain_b);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      wa_d[k] = weigh($signed(amp_a[k*AMP_W +: AMP_W]), g_a_eff);
      wb_d[k] = weigh($signed(amp_b[k*AMP_W +: AMP_W]), g_b_eff);
    end
  end

  // Pipeline stage 2: weighted tones
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (rst) begin
        wa_q[k] <= '0;
        wb_q[k] <= '0;
      end else begin
        wa_q[k] <= wa_d[k];
        wb_q[k] <= wb_d[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic signed [SUM_W-1:0] s;
      s = SUM_W'(wa_q[k]) + SUM_W'(wb_q[k]);
      word_d[k*AMP_W +: AMP_W] = saturate(s);
    end
  end

  // Pipeline stage 3: saturated sums
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end
endmodule

// File: rtl/dual_tone_iq_gen.sv
module dual_tone_iq_gen #(
  parameter int PHASE_W  = 32,
  parameter int LUT_BITS = 10,
  parameter int SAMP_W   = 16,
  parameter int SCALE_W  = 16,
  parameter int LANES    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic [PHASE_W-1:0]      ftw_i_a,
  input  logic [PHASE_W-1:0]      ftw_i_b,
  input  logic [PHASE_W-1:0]      ftw_q_a,
  input  logic [PHASE_W-1:0]      ftw_q_b,
  input  logic [SCALE_W-1:0]      gain_i_a,
  input  logic [SCALE_W-1:0]      gain_i_b,
  input  logic [SCALE_W-1:0]      gain_q_a,
  input  logic [SCALE_W-1:0]      gain_q_b,
  output logic [LANES*SAMP_W-1:0] i_word,
  output logic [LANES*SAMP_W-1:0] q_word,
  output logic                    out_valid
);
  localparam int CHANNELS     = 2;
  localparam int TONES_PER_CH = 2;
  localparam int NUM_TONES    = CHANNELS * TONES_PER_CH;
  localparam int PIPE_DEPTH   = 3;
  localparam int WORD_W       = LANES * SAMP_W;

  logic [PHASE_W-1:0] tone_ftw  [NUM_TONES];
  logic [SCALE_W-1:0] tone_gain [NUM_TONES];
  logic [WORD_W-1:0]  tone_amp  [NUM_TONES];
  logic [WORD_W-1:0]  ch_word   [CHANNELS];
  logic [PIPE_DEPTH-1:0] vpipe_q;

  assign tone_ftw[0]  = ftw_i_a;
  assign tone_ftw[1]  = ftw_i_b;
  assign tone_ftw[2]  = ftw_q_a;
  assign tone_ftw[3]  = ftw_q_b;
  assign tone_gain[0] = gain_i_a;
  assign tone_gain[1] = gain_i_b;
  assign tone_gain[2] = gain_q_a;
  assign tone_gain[3] = gain_q_b;

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    logic [LANES*LUT_BITS-1:0] lane_top;

    tone_phase_gen #(
      .PHASE_W(PHASE_W),
      .LANES  (LANES),
      .OUT_W  (LUT_BITS)
    ) phase_i (
      .clk     (clk),
      .rst     (rst),
      .clear   (clear),
      .ftw     (tone_ftw[t]),
      .lane_top(lane_top)
    );

    tone_lookup #(
      .LUT_BITS(LUT_BITS),
      .AMP_W   (SAMP_W),
      .LANES   (LANES)
    ) lookup_i (
      .clk     (clk),
      .rst     (rst),
      .lane_top(lane_top),
      .amp_q   (tone_amp[t])
    );
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    channel_mixer #(
      .AMP_W  (SAMP_W),
      .SCALE_W(SCALE_W),
      .LANES  (LANES)
    ) mix_i (
      .clk   (clk),
      .rst   (rst),
      .amp_a (tone_amp[c*TONES_PER_CH]),
      .amp_b (tone_amp[c*TONES_PER_CH + 1]),
      .gain_a(tone_gain[c*TONES_PER_CH]),
      .gain_b(tone_gain[c*TONES_PER_CH + 1]),
      .word_q(ch_word[c])
    );
  end

  // Valid tracks the data through the three register stages
  always_ff @(posedge clk) begin
    if (rst || clear) vpipe_q <= '0;
    else              vpipe_q <= {vpipe_q[PIPE_DEPTH-2:0], 1'b1};
  end

  assign i_word    = ch_word[0];
  assign q_word    = ch_word[1];
  assign out_valid = vpipe_q[PIPE_DEPTH-1];
endmodule

// File: rtl/iqgen_checker.sv
module iqgen_checker #(
  parameter int WORD_W  = 64,
  parameter int SCALE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               clear,
  input logic               out_valid,
  input logic [WORD_W-1:0]  i_word,
  input logic [WORD_W-1:0]  q_word,
  input logic [SCALE_W-1:0] gain_i_a,
  input logic [SCALE_W-1:0] gain_i_b,
  input logic [SCALE_W-1:0] gain_q_a,
  input logic [SCALE_W-1:0] gain_q_b
);
  // R6: a clear at an edge leaves valid low after it
  a_r6_clear_drops_valid: assert property (@(posedge clk) disable iff (rst)
    clear |=> !out_valid);

  // R7: valid only with three clear-free cycles behind it
  a_r7_valid_needs_history: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!$past(clear, 1) && !$past(clear, 2) && !$past(clear, 3)));

  // R7: three clear-free, reset-free cycles bring valid
  a_r7_valid_arrives: assert property (@(posedge clk) disable iff (rst)
    (!clear && !$past(clear, 1) && !$past(rst, 1) && !$past(clear, 2) && !$past(rst, 2))
    |=> out_valid);

  // R8: state right after reset
  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && i_word == '0 && q_word == '0));

  // R9: silent I channel when both gains were zero
  a_r9_zero_gain_i: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(gain_i_a, 2) == '0 && $past(gain_i_b, 2) == '0) |-> i_word == '0);

  // R9: silent Q channel when both gains were zero
  a_r9_zero_gain_q: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(gain_q_a, 2) == '0 && $past(gain_q_b, 2) == '0) |-> q_word == '0);
endmodule

bind dual_tone_iq_gen iqgen_checker #(
  .WORD_W (LANES * SAMP_W),
  .SCALE_W(SCALE_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clear    (clear),
  .out_valid(out_valid),
  .i_word   (i_word),
  .q_word   (q_word),
  .gain_i_a (gain_i_a),
  .gain_i_b (gain_i_b),
  .gain_q_a (gain_q_a),
  .gain_q_b (gain_q_b)
);

// File: tb/dual_tone_iq_gen_tb_top.sv
module dual_tone_iq_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b1;
  logic [31:0] ftw_i_a = '0, ftw_i_b = '0, ftw_q_a = '0, ftw_q_b = '0;
  logic [15:0] gain_i_a = '0, gain_i_b = '0, gain_q_a = '0, gain_q_b = '0;
  logic [63:0] i_word, q_word;
  logic out_valid;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_tone_iq_gen dut_i (
    .clk(clk), .rst(rst), .clear(clear),
    .ftw_i_a(ftw_i_a), .ftw_i_b(ftw_i_b), .ftw_q_a(ftw_q_a), .ftw_q_b(ftw_q_b),
    .gain_i_a(gain_i_a), .gain_i_b(gain_i_b), .gain_q_a(gain_q_a), .gain_q_b(gain_q_b),
    .i_word(i_word), .q_word(q_word), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  // Sine magnitude table restated in closed form
  function automatic int table_mag(input int idx);
    longint n;
    n = 2 * idx + 1;
    return int'((longint'(32767) * n * (longint'(786432) - n * n)) / 268435456);
  endfunction

  function automatic int tone_val(input logic [31:0] f, input int g, input int j);
    logic [31:0] ph;
    int top, quad, off, idx, amp, ge;
    longint pr;
    ph   = 32'(longint'(j) * longint'(f));
    top  = int'(ph >> 22);
    quad = top / 256;
    off  = top % 256;
    idx  = (quad % 2 == 1) ? 255 - off : off;
    amp  = (quad >= 2) ? -table_mag(idx) : table_mag(idx);
    ge   = (g > 32768) ? 32768 : g;
    pr   = longint'(amp) * ge;
    if (pr >= 0) return int'(pr / 32768);
    return -int'((-pr + 32767) / 32768);
  endfunction

  function automatic int exp_sample(input logic [31:0] fa, input int ga,
                                    input logic [31:0] fb, input int gb, input int j);
    int s;
    s = tone_val(fa, ga, j) + tone_val(fb, gb, j);
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic run_case(input logic [31:0] fia, input int gia, input logic [31:0] fib, input int gib,
                          input logic [31:0] fqa, input int gqa, input logic [31:0] fqb, input int gqb,
                          input int nwords, input string tag);
    int lat;
    @(negedge clk);
    clear = 1'b1;
    ftw_i_a = fia; ftw_i_b = fib; ftw_q_a = fqa; ftw_q_b = fqb;
    gain_i_a = 16'(gia); gain_i_b = 16'(gib); gain_q_a = 16'(gqa); gain_q_b = 16'(gqb);
    @(negedge clk);
    check(out_valid == 1'b0, {"R6 valid low after clear ", tag}, 64'(out_valid), 64'd0);
    @(negedge clk);
    clear = 1'b0;
    lat = 0;
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      lat++;
      if (out_valid) break;
    end
    check(lat == 3, {"R7 latency ", tag}, 64'(lat), 64'd3);
    for (int n = 0; n < nwords; n++) begin
      logic [63:0] ei, eq;
      for (int k = 0; k < 4; k++) begin
        ei[16*k +: 16] = 16'(exp_sample(fia, gia, fib, gib, 4 * n + k));
        eq[16*k +: 16] = 16'(exp_sample(fqa, gqa, fqb, gqb, 4 * n + k));
      end
      check(out_valid == 1'b1, {"R7 valid held ", tag}, 64'(out_valid), 64'd1);
      check(i_word == ei, {"R1 R2 R3 R4 R5 R10 I word ", tag}, i_word, ei);
      check(q_word == eq, {"R1 R2 R3 R4 R5 R10 Q word ", tag}, q_word, eq);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 valid in reset", 64'(out_valid), 64'd0);
    check(i_word == '0 && q_word == '0, "R8 words in reset", i_word | q_word, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after reset", 64'(out_valid), 64'd0);

    // Full table walk on I, mixed fractional tones on Q
    run_case(32'h0040_0000, 32768, 32'h0, 0,
             32'h00C0_0000, 16384, 32'h00A0_0000, 8192, 256, "walk");
    // Saturation on both rails, over-range gain clamp on Q
    run_case(32'h01C0_0000, 32768, 32'h01C0_0000, 32768,
             32'h0130_0000, 32768, 32'h0130_0000, 65535, 64, "sat");
    // R9: all gains zero
    run_case(32'h1234_5679, 0, 32'h0BAD_F00D, 0,
             32'h7777_0001, 0, 32'h0000_1000, 0, 32, "R9 zero");
    // Wrapping odd tuning words, unequal channels
    run_case(32'h1234_5679, 20000, 32'h9ABC_DEF1, 30000,
             32'hFFF0_0003, 32767, 32'h4000_0000, 1, 128, "wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule